// File: doc/BRIEF.md
# Subpage-Bitmap Translation Buffer

This block is a small, fully associative translation buffer for a DRAM main memory that is addressed like a set-associative cache. Each entry pairs an address-space identifier and a virtual large-page number with a physical DRAM page frame. Each entry also holds two 64-bit maps, one for subpage validity and one for subpage dirtiness. A large page is 32 KB and a subpage is 512 bytes, so a page has 64 subpages.

A lookup gives one of three outcomes one cycle later:
- **Page miss.** No entry matches. The block raises a request to search the set-associative tag structure. A page miss is not a fault, because the page may still be resident in DRAM.
- **Subpage miss.** The page matches but the bit for the addressed subpage is clear.
- **Full hit.** The page matches and the subpage bit is set.

The subpage outcome is decided from the map held in the entry, with no DRAM access.

The tag-structure walker loads entries through a fill port. A write port marks subpages as written. When a fill displaces a live entry, the block returns that entry's frame and both maps so that the page header in DRAM can be updated.

Top module: `tlbsp_top`

## Requirements
- R1: After synchronous reset every entry is empty, the replacement pointer is 0, and res_valid, wr_done and ev_valid are low.
- R2: A virtual address is split as follows: bits [8:0] are the byte offset and are ignored, bits [14:9] are the subpage index, and bits [39:15] are the page number.
- R3: A lookup that matches no entry on both identifier and page number returns res_kind 2'b01 (page miss) with res_walk high and res_pfn zero. The result appears one cycle after lk_valid.
- R4: A lookup that matches an entry whose valid-map bit for the subpage is set returns res_kind 2'b11 (full hit) with the entry's frame and res_walk low.
- R5: A lookup that matches an entry whose valid-map bit is clear returns res_kind 2'b10 (subpage miss) with the entry's frame and res_walk low.
- R6: A write that matches an entry sets both the valid bit and the dirty bit of the addressed subpage. wr_done is high one cycle later, with wr_hit high. A write that matches nothing alters no entry and reports wr_hit low.
- R7: A fill for a page not held in the buffer is written to the slot at the round-robin pointer. The pointer then advances by one, modulo 16, starting from slot 0.
- R8: When such a fill displaces a valid entry, ev_valid is high one cycle later and ev_asid, ev_vpn, ev_pfn, ev_vmap and ev_dmap carry the displaced entry. Filling an empty slot leaves ev_valid low.
- R9: A fill for a page already held overwrites that entry in place. It evicts nothing and leaves the pointer unchanged.
- R10: A lookup in the same cycle as a fill of the same page returns the filled contents. A lookup in the same cycle as a write returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_vaddr | input | 40 | Lookup virtual address |
| wr_valid | input | 1 | Write-marking request |
| wr_asid | input | 8 | Write address-space identifier |
| wr_vaddr | input | 40 | Write virtual address |
| fill_valid | input | 1 | Fill from the tag-structure walker |
| fill_asid | input | 8 | Fill address-space identifier |
| fill_vpn | input | 25 | Fill page number |
| fill_pfn | input | 16 | Fill DRAM frame number |
| fill_vmap | input | 64 | Fill subpage valid map |
| fill_dmap | input | 64 | Fill subpage dirty map |
| res_valid | output | 1 | Lookup result valid |
| res_kind | output | 2 | 01 page miss, 10 subpage miss, 11 full hit |
| res_pfn | output | 16 | Frame of the matched entry, else zero |
| res_walk | output | 1 | Request a tag-structure search |
| wr_done | output | 1 | Write-marking completed |
| wr_hit | output | 1 | Write found its page |
| ev_valid | output | 1 | Displaced entry returned |
| ev_asid | output | 8 | Displaced identifier |
| ev_vpn | output | 25 | Displaced page number |
| ev_pfn | output | 16 | Displaced frame |
| ev_vmap | output | 64 | Displaced valid map |
| ev_dmap | output | 64 | Displaced dirty map |

## Verification
A corrupted map bit shows up at the very next lookup of that subpage, as a full hit turned into a subpage miss or the reverse. A lost dirty bit stays hidden until the entry is displaced, when it appears in ev_dmap. A wrong replacement pointer appears on the first fill that displaces a live entry: ev_vpn names a page other than the oldest one allocated. An in-place refill that wrongly advances the pointer shifts every later eviction by one slot. The bench therefore loads all sixteen slots and checks two consecutive evictions.

// File: rtl/tlbsp_pkg.sv
package tlbsp_pkg;
    localparam int VA_W        = 40;
    localparam int OFF_W       = 9;
    localparam int SUB_W       = 6;
    localparam int NSUB        = 1 << SUB_W;
    localparam int VPN_W       = VA_W - OFF_W - SUB_W;
    localparam int ASID_W      = 8;
    localparam int PFN_W       = 16;
    localparam int ENTRIES_DEF = 16;

    typedef enum logic [1:0] {
        RES_NONE      = 2'b00,
        RES_PAGE_MISS = 2'b01,
        RES_SUB_MISS  = 2'b10,
        RES_HIT       = 2'b11
    } res_kind_e;

    typedef struct packed {
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [NSUB-1:0]   vmap;
        logic [NSUB-1:0]   dmap;
    } tlb_ent_t;

    function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W+SUB_W];
    endfunction

    function automatic logic [SUB_W-1:0] sub_of(input logic [VA_W-1:0] va);
        return va[OFF_W+SUB_W-1:OFF_W];
    endfunction
endpackage

// File: rtl/tlbsp_match.sv
module tlbsp_match
    import tlbsp_pkg::*;
#(
    parameter int N  = ENTRIES_DEF,
    parameter int IW = $clog2(N)
) (
    input  tlb_ent_t [N-1:0]    ents,
    input  logic [ASID_W-1:0]   asid,
    input  logic [VPN_W-1:0]    vpn,
    output logic                hit,
    output logic [IW-1:0]       idx
);
    logic [N-1:0] m;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign m[i] = ents[i].vld && (ents[i].asid == asid) && (ents[i].vpn == vpn);
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m[i]) idx = IW'(i);
        end
    end

    assign hit = |m;
endmodule

// File: rtl/tlbsp_rr_ptr.sv
module tlbsp_rr_ptr #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/tlbsp_top.sv
module tlbsp_top
    import tlbsp_pkg::*;
#(
    parameter int ENTRIES = ENTRIES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              wr_valid,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VA_W-1:0]   wr_vaddr,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [NSUB-1:0]   fill_vmap,
    input  logic [NSUB-1:0]   fill_dmap,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [PFN_W-1:0]  res_pfn,
    output logic              res_walk,
    output logic              wr_done,
    output logic              wr_hit,
    output logic              ev_valid,
    output logic [ASID_W-1:0] ev_asid,
    output logic [VPN_W-1:0]  ev_vpn,
    output logic [PFN_W-1:0]  ev_pfn,
    output logic [NSUB-1:0]   ev_vmap,
    output logic [NSUB-1:0]   ev_dmap
);
    localparam int IW = $clog2(ENTRIES);

    tlb_ent_t [ENTRIES-1:0] ent_q, post_ent, ent_d;
    logic [IW-1:0] rr_ptr, f_idx, l_idx, w_idx, fill_slot;
    logic          f_hit, l_hit, w_hit, alloc, evict;
    tlb_ent_t      fill_ent, victim, l_ent;
    res_kind_e     kind_d, kind_q;

    // Existing copy of the page being filled
    tlbsp_match #(.N(ENTRIES), .IW(IW)) u_fmatch (
        .ents(ent_q), .asid(fill_asid), .vpn(fill_vpn), .hit(f_hit), .idx(f_idx)
    );

    assign alloc     = fill_valid && !f_hit;
    assign fill_slot = f_hit ? f_idx : rr_ptr;
    assign victim    = ent_q[rr_ptr];
    assign evict     = alloc && victim.vld;

    tlbsp_rr_ptr #(.N(ENTRIES), .IW(IW)) u_ptr (
        .clk(clk), .rst(rst), .adv(alloc), .ptr(rr_ptr)
    );

    always_comb begin
        fill_ent = '{vld: 1'b1, asid: fill_asid, vpn: fill_vpn, pfn: fill_pfn,
                     vmap: fill_vmap, dmap: fill_dmap};
        post_ent = ent_q;
        if (fill_valid) post_ent[fill_slot] = fill_ent;
    end

    // Lookup and write both see the array after the same-cycle fill
    tlbsp_match #(.N(ENTRIES), .IW(IW)) u_lmatch (
        .ents(post_ent), .asid(lk_asid), .vpn(vpn_of(lk_vaddr)), .hit(l_hit), .idx(l_idx)
    );
    tlbsp_match #(.N(ENTRIES), .IW(IW)) u_wmatch (
        .ents(post_ent), .asid(wr_asid), .vpn(vpn_of(wr_vaddr)), .hit(w_hit), .idx(w_idx)
    );

    always_comb begin
        ent_d = post_ent;
        if (wr_valid && w_hit) begin
            ent_d[w_idx].vmap[sub_of(wr_vaddr)] = 1'b1;
            ent_d[w_idx].dmap[sub_of(wr_vaddr)] = 1'b1;
        end
    end

    assign l_ent = post_ent[l_idx];

    always_comb begin
        if (!lk_valid)                      kind_d = RES_NONE;
        else if (!l_hit)                    kind_d = RES_PAGE_MISS;
        else if (l_ent.vmap[sub_of(lk_vaddr)]) kind_d = RES_HIT;
        else                                kind_d = RES_SUB_MISS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q     <= '0;
            res_valid <= 1'b0;
            kind_q    <= RES_NONE;
            res_pfn   <= '0;
            res_walk  <= 1'b0;
            wr_done   <= 1'b0;
            wr_hit    <= 1'b0;
            ev_valid  <= 1'b0;
            ev_asid   <= '0;
            ev_vpn    <= '0;
            ev_pfn    <= '0;
            ev_vmap   <= '0;
            ev_dmap   <= '0;
        end else begin
            ent_q     <= ent_d;
            res_valid <= lk_valid;
            kind_q    <= kind_d;
            res_pfn   <= (lk_valid && l_hit) ? l_ent.pfn : '0;
            res_walk  <= lk_valid && !l_hit;
            wr_done   <= wr_valid;
            wr_hit    <= wr_valid && w_hit;
            ev_valid  <= evict;
            if (evict) begin
                ev_asid <= victim.asid;
                ev_vpn  <= victim.vpn;
                ev_pfn  <= victim.pfn;
                ev_vmap <= victim.vmap;
                ev_dmap <= victim.dmap;
            end
        end
    end

    assign res_kind = kind_q;
endmodule

// File: rtl/tlbsp_chk.sv
module tlbsp_chk #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          lk_valid,
    input logic          wr_valid,
    input logic          fill_valid,
    input logic          res_valid,
    input logic [1:0]    res_kind,
    input logic [15:0]   res_pfn,
    input logic          res_walk,
    input logic          wr_done,
    input logic          ev_valid,
    input logic [IW-1:0] rr_ptr
);
    AST_RES_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid); // R3
    AST_WALK_ONLY_ON_PAGE_MISS: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_walk == (res_kind == 2'b01))); // R3
    AST_PFN_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'b01) |-> (res_pfn == '0)); // R3
    AST_KIND_DEFINED: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_kind != 2'b00)); // R4
    AST_WRITE_ACK: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> wr_done); // R6
    AST_EVICT_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> $past(fill_valid)); // R8
    AST_PTR_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rr_ptr) |-> (rr_ptr == $past(rr_ptr) + 1'b1)); // R7
    AST_PTR_MOVES_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (rst)
        !$stable(rr_ptr) |-> $past(fill_valid)); // R9
endmodule

bind tlbsp_top tlbsp_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .wr_valid(wr_valid),
    .fill_valid(fill_valid), .res_valid(res_valid), .res_kind(res_kind),
    .res_pfn(res_pfn), .res_walk(res_walk), .wr_done(wr_done),
    .ev_valid(ev_valid), .rr_ptr(rr_ptr)
);

// File: tb/tb_tlbsp_top.sv
module tb_tlbsp_top;
    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    logic        lk_valid, wr_valid, fill_valid;
    logic [7:0]  lk_asid, wr_asid, fill_asid;
    logic [39:0] lk_vaddr, wr_vaddr;
    logic [24:0] fill_vpn;
    logic [15:0] fill_pfn;
    logic [63:0] fill_vmap, fill_dmap;
    logic        res_valid, res_walk, wr_done, wr_hit, ev_valid;
    logic [1:0]  res_kind;
    logic [15:0] res_pfn, ev_pfn;
    logic [7:0]  ev_asid;
    logic [24:0] ev_vpn;
    logic [63:0] ev_vmap, ev_dmap;

    int nchecks = 0;
    int nfail   = 0;

    tlbsp_top dut (.*);

    typedef struct packed {
        logic [1:0]  op;    // 0 lookup, 1 write, 2 fill
        logic [7:0]  asid;
        logic [24:0] vpn;
        logic [5:0]  sub;
        logic [8:0]  off;
        logic [15:0] pfn;   // fill frame, or expected lookup frame
        logic [63:0] vmap;
        logic [1:0]  ekind;
        logic        eflag; // expected wr_hit or ev_valid
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'd3, 25'h100, 6'd5, 9'h000, 16'h0000, 64'h0,  2'b01, 1'b0}, // R3
        '{2'd2, 8'd3, 25'h100, 6'd0, 9'h000, 16'h00AB, 64'h20, 2'b00, 1'b0}, // R8 empty slot
        '{2'd0, 8'd3, 25'h100, 6'd5, 9'h1FF, 16'h00AB, 64'h0,  2'b11, 1'b0}, // R4 R2
        '{2'd0, 8'd3, 25'h100, 6'd6, 9'h0A5, 16'h00AB, 64'h0,  2'b10, 1'b0}, // R5 R2
        '{2'd0, 8'd4, 25'h100, 6'd5, 9'h000, 16'h0000, 64'h0,  2'b01, 1'b0}, // R3 asid
        '{2'd0, 8'd3, 25'h101, 6'd5, 9'h000, 16'h0000, 64'h0,  2'b01, 1'b0}, // R3 vpn
        '{2'd1, 8'd3, 25'h100, 6'd6, 9'h033, 16'h0000, 64'h0,  2'b00, 1'b1}, // R6
        '{2'd0, 8'd3, 25'h100, 6'd6, 9'h000, 16'h00AB, 64'h0,  2'b11, 1'b0}, // R6
        '{2'd1, 8'd3, 25'h200, 6'd1, 9'h000, 16'h0000, 64'h0,  2'b00, 1'b0}, // R6 miss
        '{2'd0, 8'd3, 25'h200, 6'd1, 9'h000, 16'h0000, 64'h0,  2'b01, 1'b0}, // R6
        '{2'd0, 8'd3, 25'h100, 6'd1, 9'h000, 16'h00AB, 64'h0,  2'b10, 1'b0}  // R6 no stray bit
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 0; wr_valid = 0; fill_valid = 0;
        lk_asid = 0; wr_asid = 0; fill_asid = 0;
        lk_vaddr = 0; wr_vaddr = 0; fill_vpn = 0; fill_pfn = 0;
        fill_vmap = 0; fill_dmap = 0;
    endtask

    function automatic logic [39:0] va(input logic [24:0] vpn, input logic [5:0] sub,
                                       input logic [8:0] off);
        return {vpn, sub, off};
    endfunction

    task automatic set_lk(input logic [7:0] a, input logic [24:0] v, input logic [5:0] s);
        lk_valid = 1; lk_asid = a; lk_vaddr = va(v, s, 9'h0);
    endtask

    task automatic set_fill(input logic [7:0] a, input logic [24:0] v, input logic [15:0] p,
                            input logic [63:0] vm);
        fill_valid = 1; fill_asid = a; fill_vpn = v; fill_pfn = p; fill_vmap = vm; fill_dmap = 0;
    endtask

    // inputs set at a falling edge, captured at the rising edge, read at the next falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 res_valid after reset", 64'(res_valid), 64'd0);
        chk("R1 wr_done after reset", 64'(wr_done), 64'd0);
        chk("R1 ev_valid after reset", 64'(ev_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            case (v.op)
                2'd0: begin lk_valid = 1; lk_asid = v.asid; lk_vaddr = va(v.vpn, v.sub, v.off); end
                2'd1: begin wr_valid = 1; wr_asid = v.asid; wr_vaddr = va(v.vpn, v.sub, v.off); end
                default: set_fill(v.asid, v.vpn, v.pfn, v.vmap);
            endcase
            tick();
            idle();
            case (v.op)
                2'd0: begin
                    chk($sformatf("R3/R4/R5 vec%0d kind", i), 64'(res_kind), 64'(v.ekind));
                    chk($sformatf("R3/R4/R5 vec%0d pfn", i), 64'(res_pfn), 64'(v.pfn));
                    chk($sformatf("R3 vec%0d walk", i), 64'(res_walk), 64'(v.ekind == 2'b01));
                end
                2'd1: begin
                    chk($sformatf("R6 vec%0d wr_done", i), 64'(wr_done), 64'd1);
                    chk($sformatf("R6 vec%0d wr_hit", i), 64'(wr_hit), 64'(v.eflag));
                end
                default: chk($sformatf("R8 vec%0d ev_valid", i), 64'(ev_valid), 64'(v.eflag));
            endcase
        end

        // R10: lookup and write in one cycle, lookup sees pre-write state
        set_lk(8'd3, 25'h100, 6'd9);
        wr_valid = 1; wr_asid = 8'd3; wr_vaddr = va(25'h100, 6'd9, 9'h0);
        tick(); idle();
        chk("R10 lookup before write kind", 64'(res_kind), 64'b10);
        chk("R6 same-cycle write hit", 64'(wr_hit), 64'd1);
        set_lk(8'd3, 25'h100, 6'd9);
        tick(); idle();
        chk("R6 later lookup kind", 64'(res_kind), 64'b11);

        // R10: fill and lookup of the same page in one cycle (slot 1)
        set_fill(8'd3, 25'h300, 16'h0011, 64'h4);
        set_lk(8'd3, 25'h300, 6'd2);
        tick(); idle();
        chk("R10 fill-bypass kind", 64'(res_kind), 64'b11);
        chk("R10 fill-bypass pfn", 64'(res_pfn), 64'h11);

        // R7: slots 2..15 filled, none displaces
        begin
            int evs = 0;
            for (int k = 1; k < 15; k++) begin
                set_fill(8'd3, 25'h300 + 25'(k), 16'h0020 + 16'(k), 64'h0);
                tick(); idle();
                if (ev_valid) evs++;
            end
            chk("R8 no eviction while slots empty", 64'(evs), 64'd0);
        end

        // R7 R8: buffer full, oldest slot 0 goes out with its maps
        set_fill(8'd3, 25'h400, 16'h0040, 64'h0);
        tick(); idle();
        chk("R8 ev_valid", 64'(ev_valid), 64'd1);
        chk("R7 ev_vpn slot0", 64'(ev_vpn), 64'h100);
        chk("R8 ev_asid", 64'(ev_asid), 64'd3);
        chk("R8 ev_pfn", 64'(ev_pfn), 64'hAB);
        chk("R8 ev_vmap", 64'(ev_vmap), 64'h260);
        chk("R8 ev_dmap", 64'(ev_dmap), 64'h240);

        set_lk(8'd3, 25'h100, 6'd5);
        tick(); idle();
        chk("R7 evicted page misses", 64'(res_kind), 64'b01);

        // R9: refill of a held page in place
        set_fill(8'd3, 25'h302, 16'h0077, 64'h0);
        tick(); idle();
        chk("R9 in-place fill no eviction", 64'(ev_valid), 64'd0);
        set_lk(8'd3, 25'h302, 6'd0);
        tick(); idle();
        chk("R9 in-place frame", 64'(res_pfn), 64'h77);
        chk("R9 in-place kind", 64'(res_kind), 64'b10);

        // R9 R7: pointer did not move, so slot 1 goes next
        set_fill(8'd3, 25'h401, 16'h0041, 64'h0);
        tick(); idle();
        chk("R9 next victim valid", 64'(ev_valid), 64'd1);
        chk("R9 next victim vpn", 64'(ev_vpn), 64'h300);
        chk("R9 next victim pfn", 64'(ev_pfn), 64'h11);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule